// File: doc/BRIEF.md
# Edge-Pulse Isolation Link Codec

This block models a digital channel that carries a logic level across a barrier as a stream of short pulses instead of as the level itself. On the transmit side an encoder synchronizes the logic input, watches it for transitions, and answers each rising transition with a short pulse on a set line and each falling transition with a short pulse on a clear line. While the input stays quiet it keeps the far side up to date: at a fixed interval it sends a refresh pulse of the kind that matches the present level.

On the receive side a decoder keeps a two-state value that the pulses set and clear. It drives the output from that value. A watchdog counts cycles with no valid pulse. When the count reaches its limit, the output is forced to a chosen default level and a link fault flag is raised. The next valid pulse takes back control of the output and clears the flag. The barrier is outside the block: the encoder's pulse lines are outputs, the decoder's pulse lines are inputs, and the integrator connects them through whatever medium sits in between. All time constants are parameters counted in clock cycles.

Top module: `pulse_iso_link`

## Requirements
- R1: While reset is held and until the first valid pulse arrives, `tx_set` and `tx_clr` are low, `data_out` equals DEFAULT_OUT and `link_fault` is high.
- R2: A rising transition on `data_in` raises `tx_set`, and the pulse is visible after the third rising clock edge that follows the change. That latency is two synchronizer stages plus one edge-detection register.
- R3: A falling transition on `data_in` raises `tx_clr` with the same three-edge latency as R2.
- R4: Each pulse lasts exactly PULSE_CYCLES clock cycles. A pulse that follows another of the same kind with no gap lengthens the high run to a whole multiple of PULSE_CYCLES.
- R5: `tx_set` and `tx_clr` are never high in the same cycle. A transition that arrives while a pulse is still running is queued. The queued pulse starts in the cycle right after the running one ends, and its kind follows the input level at that time.
- R6: While `data_in` holds still, a refresh pulse of the matching kind (`tx_set` for high, `tx_clr` for low) starts every REFRESH_CYCLES cycles. The interval is measured from the start of the previous pulse, and any input transition restarts it.
- R7: A cycle with `rx_set` high and `rx_clr` low makes `data_out` high after the next edge. A cycle with `rx_clr` high and `rx_set` low makes it low. With neither line high, the output holds its value.
- R8: A cycle in which `rx_set` and `rx_clr` are both high is not a valid pulse. It changes neither `data_out` nor the watchdog count.
- R9: Suppose the last valid pulse cycle is sampled at edge T and no valid pulse follows. Then `data_out` becomes DEFAULT_OUT and `link_fault` rises at edge T+WDOG_CYCLES, and not before.
- R10: After a fault, the next valid pulse sets `data_out` to that pulse's level and clears `link_fault` at the following edge.
- R11: When the pulse outputs are looped straight back to the pulse inputs, `data_out` settles to `data_in` within 2*PULSE_CYCLES+6 cycles of a transition, and `link_fault` never rises once the first pulse has arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | 1 | Logic level to carry across the link (asynchronous) |
| tx_set | output | 1 | Encoder set pulse (input went or stays high) |
| tx_clr | output | 1 | Encoder clear pulse (input went or stays low) |
| rx_set | input | 1 | Set pulse received from the barrier |
| rx_clr | input | 1 | Clear pulse received from the barrier |
| data_out | output | 1 | Rebuilt logic level |
| link_fault | output | 1 | High while the watchdog holds the output at its default |

## Verification
Two events can fall in the same cycle on each side of the link. In the encoder, a new input transition can land while a pulse is still running. The bench provokes this with input toggles spaced one cycle apart and with short random hold times. It judges the result by requiring a queued pulse of the right kind in the cycle after the running one ends, and by requiring that the two pulse lines never overlap and that every pulse run is a whole multiple of PULSE_CYCLES. In the decoder, a both-lines-high cycle can fall inside the watchdog window while the link is cut. The bench checks that such a cycle neither moves the output nor delays the fault, which must still arrive at exactly the edge R9 predicts.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

    typedef enum logic {
        KIND_CLR = 1'b0,
        KIND_SET = 1'b1
    } pulse_kind_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/iso_sync.sv
module iso_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (STAGES > 1) begin
            state_d.chain = {state_q.chain[STAGES-2:0], async_i};
        end else begin
            state_d.chain[0] = async_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_o = state_q.chain[STAGES-1];

endmodule

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder
    import iso_link_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES   = 2,
    parameter int unsigned REFRESH_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic tx_set_o,
    output logic tx_clr_o
);
    localparam int unsigned PW = cnt_width(PULSE_CYCLES + 1);
    localparam int unsigned RW = cnt_width(REFRESH_CYCLES);

    typedef struct packed {
        logic        lvl;
        logic [PW-1:0] pcnt;
        pulse_kind_e kind;
        logic        pend;
        logic [RW-1:0] rcnt;
    } enc_state_t;

    enc_state_t state_d, state_q;
    logic       edge_seen, active, free_slot, refresh_due, request;

    always_comb begin
        state_d     = state_q;
        state_d.lvl = level_i;
        edge_seen   = level_i ^ state_q.lvl;
        active      = (state_q.pcnt != '0);
        free_slot   = !active || (state_q.pcnt == PW'(1));
        refresh_due = !edge_seen && (state_q.rcnt == RW'(REFRESH_CYCLES - 1));
        request     = edge_seen || refresh_due || state_q.pend;

        if (active) state_d.pcnt = state_q.pcnt - PW'(1);

        if (edge_seen || refresh_due) state_d.rcnt = '0;
        else                          state_d.rcnt = state_q.rcnt + RW'(1);

        if (request) begin
            if (free_slot) begin
                state_d.pcnt = PW'(PULSE_CYCLES);
                state_d.kind = level_i ? KIND_SET : KIND_CLR;
                state_d.pend = 1'b0;
            end else begin
                state_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.kind <= KIND_CLR;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_set_o = (state_q.pcnt != '0) && (state_q.kind == KIND_SET);
    assign tx_clr_o = (state_q.pcnt != '0) && (state_q.kind == KIND_CLR);

    // R2 / R3: a detected transition is either launched at full width or queued
    a_r2_edge_serviced : assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (state_q.pend || state_q.pcnt == PW'(PULSE_CYCLES)));

    // R6: a refresh in a free slot repeats the level seen when it fell due
    a_r6_refresh_level : assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_due && free_slot) |=> ((tx_set_o || tx_clr_o) && (tx_set_o == $past(level_i))));

    // R5: a queued pulse starts as soon as the running one finishes
    a_r5_queue_drains : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.pend && state_q.pcnt == PW'(1)) |=> (tx_set_o || tx_clr_o));

endmodule

// File: rtl/iso_pulse_decoder.sv
module iso_pulse_decoder
    import iso_link_pkg::*;
#(
    parameter int unsigned WDOG_CYCLES = 200,
    parameter logic        DEFAULT_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_set_i,
    input  logic rx_clr_i,
    output logic level_o,
    output logic fault_o
);
    localparam int unsigned WW = cnt_width(WDOG_CYCLES);

    typedef struct packed {
        logic          out;
        logic          fault;
        logic [WW-1:0] wcnt;
    } dec_state_t;

    dec_state_t state_d, state_q;
    logic       set_only, clr_only, wdog_expire;

    always_comb begin
        state_d     = state_q;
        set_only    = rx_set_i && !rx_clr_i;
        clr_only    = rx_clr_i && !rx_set_i;
        wdog_expire = !state_q.fault && (state_q.wcnt == WW'(WDOG_CYCLES - 1));

        if (set_only || clr_only) begin
            state_d.out   = set_only;
            state_d.fault = 1'b0;
            state_d.wcnt  = '0;
        end else if (wdog_expire) begin
            state_d.out   = DEFAULT_OUT;
            state_d.fault = 1'b1;
        end else if (!state_q.fault) begin
            state_d.wcnt  = state_q.wcnt + WW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.out   <= DEFAULT_OUT;
            state_q.fault <= 1'b1;
            state_q.wcnt  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign level_o = state_q.out;
    assign fault_o = state_q.fault;

    // R7 / R10: a lone set pulse drives high and clears any fault
    a_r7_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_i && !rx_clr_i) |=> (level_o && !fault_o));

    // R7 / R10: a lone clear pulse drives low and clears any fault
    a_r7_clr_wins : assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr_i && !rx_set_i) |=> (!level_o && !fault_o));

    // R8: both lines high is ignored unless the watchdog is expiring anyway
    a_r8_both_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set_i && rx_clr_i && !wdog_expire) |=> $stable(level_o));

    // R9: a faulted link always shows the default level
    a_r9_fault_default : assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (level_o == DEFAULT_OUT));

endmodule

// File: rtl/pulse_iso_link.sv
module pulse_iso_link #(
    parameter int unsigned PULSE_CYCLES   = 2,
    parameter int unsigned REFRESH_CYCLES = 40,
    parameter int unsigned WDOG_CYCLES    = 200,
    parameter logic        DEFAULT_OUT    = 1'b0,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic tx_set,
    output logic tx_clr,
    input  logic rx_set,
    input  logic rx_clr,
    output logic data_out,
    output logic link_fault
);
    logic level_sync;

    iso_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (data_in),
        .sync_o  (level_sync)
    );

    iso_edge_encoder #(
        .PULSE_CYCLES  (PULSE_CYCLES),
        .REFRESH_CYCLES(REFRESH_CYCLES)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_sync),
        .tx_set_o (tx_set),
        .tx_clr_o (tx_clr)
    );

    iso_pulse_decoder #(
        .WDOG_CYCLES(WDOG_CYCLES),
        .DEFAULT_OUT(DEFAULT_OUT)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_set_i (rx_set),
        .rx_clr_i (rx_clr),
        .level_o  (data_out),
        .fault_o  (link_fault)
    );

endmodule

// File: tb/test_pulse_iso_link.sv
`timescale 1ns/1ps
module test_pulse_iso_link;
    localparam int unsigned P   = 2;
    localparam int unsigned R   = 40;
    localparam int unsigned W   = 200;
    localparam logic        DEF = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic cut = 1'b0, man_set = 1'b0, man_clr = 1'b0;
    logic tx_set, tx_clr, data_out, link_fault;
    logic rx_set, rx_clr;
    int   n_chk = 0, n_fail = 0;
    int   both_seen = 0, bad_width = 0, loop_faults = 0;
    int   run_set = 0, run_clr = 0;
    bit   armed = 1'b0;

    always #4 clk = ~clk;

    assign rx_set = cut ? man_set : tx_set;
    assign rx_clr = cut ? man_clr : tx_clr;

    pulse_iso_link #(
        .PULSE_CYCLES(P), .REFRESH_CYCLES(R), .WDOG_CYCLES(W), .DEFAULT_OUT(DEF)
    ) i_pulse_iso_link (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .tx_set(tx_set), .tx_clr(tx_clr),
        .rx_set(rx_set), .rx_clr(rx_clr),
        .data_out(data_out), .link_fault(link_fault)
    );

    function automatic int settle_limit();
        return 2 * P + 6;
    endfunction

    function automatic bit width_ok(input int run);
        return (run % P) == 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // pulse-line monitor for R4, R5, R11
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_set && tx_clr) both_seen++;
            if (tx_set) run_set++;
            else begin
                if (run_set != 0 && !width_ok(run_set)) bad_width++;
                run_set = 0;
            end
            if (tx_clr) run_clr++;
            else begin
                if (run_clr != 0 && !width_ok(run_clr)) bad_width++;
                run_clr = 0;
            end
            if (armed && !cut && link_fault) loop_faults++;
        end
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1C0D));
        // R1: reset state
        tick(3);
        chk(!tx_set && !tx_clr, "R1 tx lines in reset", {tx_set, tx_clr}, 0);
        chk(data_out == DEF, "R1 data_out in reset", data_out, DEF);
        chk(link_fault == 1'b1, "R1 link_fault in reset", link_fault, 1);
        rst_n = 1'b1;

        // R2: rising edge latency, R4 width
        data_in = 1'b1;
        tick(2);
        chk(!tx_set, "R2 no set before third edge", tx_set, 0);
        chk(link_fault == 1'b1, "R1 fault until first pulse", link_fault, 1);
        tick(1);
        chk(tx_set && !tx_clr, "R2 set pulse at third edge", tx_set, 1);
        tick(P - 1);
        chk(tx_set, "R4 set still high at last pulse cycle", tx_set, 1);
        tick(1);
        chk(!tx_set, "R4 set ends after PULSE_CYCLES", tx_set, 0);
        chk(data_out == 1'b1 && !link_fault, "R7 R10 output follows set", data_out, 1);
        armed = 1'b1;

        // R6: refresh R cycles after pulse start (start was edge 3)
        tick(R - P - 1);
        chk(!tx_set, "R6 no refresh before interval", tx_set, 0);
        tick(1);
        chk(tx_set && !tx_clr, "R6 refresh matches high level", tx_set, 1);
        tick(R);
        chk(tx_set, "R6 second refresh one interval later", tx_set, 1);
        tick(P + 3);

        // R3: falling edge
        data_in = 1'b0;
        tick(3);
        chk(tx_clr && !tx_set, "R3 clear pulse at third edge", tx_clr, 1);
        tick(1);
        chk(data_out == 1'b0, "R7 output follows clear", data_out, 0);
        tick(R + 5);
        // R6 low refresh: next must be a clear pulse
        begin
            int guard = 0;
            while (!tx_set && !tx_clr && guard < 2 * R) begin tick(1); guard++; end
            chk(tx_clr && !tx_set, "R6 refresh matches low level", tx_clr, 1);
        end
        tick(P + 2);

        // R5: edge during running pulse gets queued
        data_in = 1'b1;
        tick(1);
        data_in = 1'b0;
        tick(2);
        chk(tx_set, "R5 first pulse set", tx_set, 1);
        tick(P);
        chk(tx_clr && !tx_set, "R5 queued clear right after", tx_clr, 1);
        tick(settle_limit());
        chk(data_out == 1'b0, "R11 settles after queued pair", data_out, 0);

        // R8, R9, R10 with the link cut
        cut = 1'b1;
        man_clr = 1'b1;
        tick(1);                       // edge T sampled clear
        man_clr = 1'b0;
        chk(data_out == 1'b0 && !link_fault, "R7 manual clear", data_out, 0);
        tick(4);
        man_set = 1'b1; man_clr = 1'b1;
        tick(1);                       // edge T+5 both high
        man_set = 1'b0; man_clr = 1'b0;
        chk(data_out == 1'b0, "R8 both high ignored", data_out, 0);
        tick(W - 6);                   // after edge T+W-1
        chk(!link_fault && data_out == 1'b0, "R9 no fault before limit", link_fault, 0);
        tick(1);                       // after edge T+W
        chk(link_fault && data_out == DEF, "R9 fault and default at limit", link_fault, 1);
        man_clr = 1'b1;
        tick(1);
        man_clr = 1'b0;
        chk(!link_fault && data_out == 1'b0, "R10 recovery clears fault", data_out, 0);
        tick(3);
        cut = 1'b0;
        tick(R + P + 2);

        // R11 constrained random loopback traffic
        for (int i = 0; i < 300; i++) begin
            int hold;
            hold = ($urandom_range(0, 3) == 0) ? $urandom_range(1, P + 1)
                                                : $urandom_range(1, 3 * R);
            data_in = ~data_in;
            tick(hold);
            if (hold >= settle_limit())
                chk(data_out == data_in, "R11 random settle", data_out, data_in);
        end
        tick(settle_limit());
        chk(data_out == data_in, "R11 final settle", data_out, data_in);
        tick(W + R);
        chk(data_out == data_in, "R6 R11 idle link holds level", data_out, data_in);

        chk(both_seen == 0, "R5 never both lines", both_seen, 0);
        chk(bad_width == 0, "R4 pulse runs multiple of width", bad_width, 0);
        chk(loop_faults == 0, "R11 no fault on healthy loop", loop_faults, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule